// File: doc/BRIEF.md
# Push-Button Up/Down Counter Controller

This block turns three push-button inputs into a slowly stepping 8-bit count. The buttons are up, down and pause. Each button input is brought into the system clock domain by a two-flop synchroniser, and only its rising edge is used. A small mode machine records what the counter is doing: idle, counting up, counting down, or held. A two-stage clock divider produces a slow step pulse. On each step the count register moves by one in the current direction.

A direction press starts counting, or changes its direction. A pause press freezes the value. A later direction press resumes from the frozen value rather than from zero. The block is meant to sit between raw button pins and a display path. The slow step rate lets a person watch the value change.

Top module: `updown_button_counter`

## Requirements
- R1: While the synchronous active-low reset `rst_n` is low at a rising clock edge, the count becomes 0 and the mode becomes idle, whatever the buttons do.
- R2: After reset the count stays 0 until a direction press is captured. A pause press in idle has no effect.
- R3: A captured down press makes the count decrease by one on every step pulse.
- R4: A captured up press makes the count increase by one on every step pulse. This also applies when the counter is already counting down, which switches it to counting up.
- R5: A captured pause press while counting freezes the count for as long as the block stays held.
- R6: A direction press while held resumes counting in that direction from the frozen value.
- R7: Each button acts only on its rising edge, so a held button acts once. A button level first sampled high at clock edge k changes the mode at edge k+2.
- R8: When several presses are captured in the same cycle, up wins over down, and down wins over pause.
- R9: The count wraps modulo 256 in both directions: 255 plus one gives 0, and 0 minus one gives 255.
- R10: The step divider has two cascaded counters with periods `DIV_LO` and `DIV_HI` (default 5000 each). A tick level toggles each time the second counter wraps, and a step occurs when the tick rises. The first step after reset falls on the `DIV_LO*DIV_HI`-th edge after reset is released. Later steps follow every `2*DIV_LO*DIV_HI` edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| btn_up | input | 1 | Raw up button, asynchronous, high when pressed |
| btn_down | input | 1 | Raw down button, asynchronous, high when pressed |
| btn_pause | input | 1 | Raw pause button, asynchronous, high when pressed |
| count | output | 8 | Current count value |

## Verification
The in-line assertions check the following on every cycle:
- reset forces idle mode and a zero count;
- idle never moves straight to held;
- a captured up press always wins;
- an edge pulse lasts one cycle;
- step pulses never come back to back;
- the count moves by exactly one in the active direction on a step, and stays put otherwise.

Only the bench's scenarios show the behaviours that span many cycles, by comparing against a reference model on every clock. These are the exact step spacing, resume from the held value, a held button acting once, and wrap-around across the whole range.

// File: rtl/ubc_pkg.sv
// Package: shared types and constants of the button counter.
// Assumes: bit positions of the button vector are fixed by BTN_* below.
package ubc_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_UP   = 2'd1,
        MODE_DOWN = 2'd2,
        MODE_HOLD = 2'd3
    } ubc_mode_e;

    localparam int NUM_BTN = 3;
    localparam int BTN_UP  = 0;
    localparam int BTN_DN  = 1;
    localparam int BTN_PS  = 2;

endpackage

// File: rtl/ubc_btn_sync.sv
// Module: brings WIDTH asynchronous button levels into the clock domain
// through two flops each, and emits a one-cycle pulse on each rising edge.
// Assumes: inputs are held high for at least two clock cycles per press.
module ubc_btn_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] rise
);

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_btn
            logic meta_q;
            logic sync_q;
            logic last_q;

            // Two-flop synchroniser followed by a history flop for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    sync_q <= 1'b0;
                    last_q <= 1'b0;
                end else begin
                    meta_q <= raw[gi];
                    sync_q <= meta_q;
                    last_q <= sync_q;
                end
            end

            assign rise[gi] = sync_q & ~last_q;

            AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
                rise[gi] |=> !rise[gi]); // R7
        end
    endgenerate

endmodule

// File: rtl/ubc_step_div.sv
// Module: two cascaded counters divide the clock. A tick level toggles on each
// wrap of the second counter, and step pulses for one cycle when the tick rises.
// Assumes: DIV_LO and DIV_HI are at least 1.
module ubc_step_div #(
    parameter int DIV_LO = 5000,
    parameter int DIV_HI = 5000
) (
    input  logic clk,
    input  logic rst_n,
    output logic step
);

    localparam int LO_W = (DIV_LO > 1) ? $clog2(DIV_LO) : 1;
    localparam int HI_W = (DIV_HI > 1) ? $clog2(DIV_HI) : 1;
    localparam logic [LO_W-1:0] LO_LAST = LO_W'(DIV_LO - 1);
    localparam logic [HI_W-1:0] HI_LAST = HI_W'(DIV_HI - 1);

    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;
    logic            tick_q;
    logic            lo_wrap;
    logic            hi_wrap;

    assign lo_wrap = (lo_q == LO_LAST);
    assign hi_wrap = lo_wrap && (hi_q == HI_LAST);

    // First stage: free-running counter of period DIV_LO.
    always_ff @(posedge clk) begin
        if (!rst_n)       lo_q <= '0;
        else if (lo_wrap) lo_q <= '0;
        else              lo_q <= lo_q + 1'b1;
    end

    // Second stage: advances once per first-stage wrap, period DIV_HI.
    always_ff @(posedge clk) begin
        if (!rst_n)       hi_q <= '0;
        else if (hi_wrap) hi_q <= '0;
        else if (lo_wrap) hi_q <= hi_q + 1'b1;
    end

    // Tick level: toggles on every second-stage wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)       tick_q <= 1'b0;
        else if (hi_wrap) tick_q <= ~tick_q;
    end

    assign step = hi_wrap && !tick_q;

    AST_STEP_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step); // R10

endmodule

// File: rtl/ubc_mode_fsm.sv
// Module: keeps the counting mode, updated from captured button edges.
// Priority among same-cycle presses: up, then down, then pause.
// Assumes: press inputs are single-cycle pulses.
module ubc_mode_fsm
    import ubc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BTN-1:0] press,
    output ubc_mode_e          mode
);

    ubc_mode_e mode_q;
    ubc_mode_e mode_d;

    // Next-mode selection with fixed press priority.
    always_comb begin
        mode_d = mode_q;
        if (press[BTN_UP]) begin
            mode_d = MODE_UP;
        end else if (press[BTN_DN]) begin
            mode_d = MODE_DOWN;
        end else if (press[BTN_PS]) begin
            if (mode_q == MODE_UP || mode_q == MODE_DOWN) mode_d = MODE_HOLD;
        end
    end

    // Mode register, returned to idle by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_IDLE;
        else        mode_q <= mode_d;
    end

    assign mode = mode_q;

    AST_RESET_TO_IDLE: assert property (@(posedge clk)
        !rst_n |=> mode_q == MODE_IDLE); // R1
    AST_IDLE_NEVER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == MODE_IDLE |=> mode_q != MODE_HOLD); // R2
    AST_UP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        press[BTN_UP] |=> mode_q == MODE_UP); // R8
    AST_DOWN_OVER_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (press[BTN_DN] && !press[BTN_UP]) |=> mode_q == MODE_DOWN); // R8

endmodule

// File: rtl/ubc_count_reg.sv
// Module: the count register; moves by one per step in the current direction
// and wraps modulo 2**CNT_W.
// Assumes: step is a single-cycle pulse.
module ubc_count_reg
    import ubc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  ubc_mode_e        mode,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] cnt_q;

    // Count update: one step up or down, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step) begin
            case (mode)
                MODE_UP:   cnt_q <= cnt_q + 1'b1;
                MODE_DOWN: cnt_q <= cnt_q - 1'b1;
                default:   cnt_q <= cnt_q;
            endcase
        end
    end

    assign count = cnt_q;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> cnt_q == '0); // R1
    AST_STILL_WHEN_NOT_COUNTING: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IDLE || mode == MODE_HOLD) |=> $stable(cnt_q)); // R5
    AST_NO_STEP_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt_q)); // R10
    AST_UP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode == MODE_UP) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R4
    AST_DOWN_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode == MODE_DOWN) |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1)); // R3

endmodule

// File: rtl/updown_button_counter.sv
// Module: top of the button-driven up/down counter. It chains the button
// synchroniser, the mode machine, the step divider and the count register.
// Assumes: buttons are already debounced, or bounce is acceptable.
module updown_button_counter
    import ubc_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int DIV_LO = 5000,
    parameter int DIV_HI = 5000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             btn_up,
    input  logic             btn_down,
    input  logic             btn_pause,
    output logic [CNT_W-1:0] count
);

    logic [NUM_BTN-1:0] raw_btn;
    logic [NUM_BTN-1:0] press;
    logic               step;
    ubc_mode_e          mode;

    // Pack the raw buttons into their fixed vector positions.
    always_comb begin
        raw_btn         = '0;
        raw_btn[BTN_UP] = btn_up;
        raw_btn[BTN_DN] = btn_down;
        raw_btn[BTN_PS] = btn_pause;
    end

    ubc_btn_sync #(.WIDTH(NUM_BTN)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw_btn),
        .rise  (press)
    );

    ubc_mode_fsm i_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .press (press),
        .mode  (mode)
    );

    ubc_step_div #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step)
    );

    ubc_count_reg #(.CNT_W(CNT_W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .mode  (mode),
        .count (count)
    );

endmodule

// File: tb/test_updown_button_counter.sv
// Bench: behavioural reference model advanced on every clock, compared each cycle.
module test_updown_button_counter;

    localparam int LO = 4;
    localparam int HI = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       b_up = 1'b0;
    logic       b_dn = 1'b0;
    logic       b_ps = 1'b0;
    logic [7:0] count;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Reference model state.
    bit [2:0] hist[$];
    int m_mode = 0; // 0 idle, 1 up, 2 down, 3 hold
    int m_cnt = 0;
    int m_lo = 0;
    int m_hi = 0;
    int m_tick = 0;

    always #4 clk = ~clk;

    updown_button_counter #(.CNT_W(8), .DIV_LO(LO), .DIV_HI(HI)) i_updown_button_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .btn_up    (b_up),
        .btn_down  (b_dn),
        .btn_pause (b_ps),
        .count     (count)
    );

    // Advance the reference model at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{3'b000, 3'b000, 3'b000};
            m_mode = 0; m_cnt = 0; m_lo = 0; m_hi = 0; m_tick = 0;
        end else begin
            bit [2:0] edg;
            bit       stp;
            edg = hist[1] & ~hist[2];
            stp = (m_lo == LO - 1) && (m_hi == HI - 1) && (m_tick == 0);
            if (stp && m_mode == 1) m_cnt = (m_cnt + 1) % 256;
            if (stp && m_mode == 2) m_cnt = (m_cnt + 255) % 256;
            if (edg[0]) m_mode = 1;
            else if (edg[1]) m_mode = 2;
            else if (edg[2] && (m_mode == 1 || m_mode == 2)) m_mode = 3;
            if (m_lo == LO - 1) begin
                m_lo = 0;
                if (m_hi == HI - 1) begin
                    m_hi = 0;
                    m_tick = 1 - m_tick;
                end else m_hi++;
            end else m_lo++;
            hist.push_front({b_ps, b_dn, b_up});
            void'(hist.pop_back());
        end
    end

    // Compare against the model away from the active edge.
    always @(negedge clk) begin
        if (!done && hist.size() == 3) begin
            n_checks++;
            if (count !== 8'(m_cnt)) begin
                n_fail++;
                $display("FAIL %s: count actual %0d expected %0d", cur_req, count, m_cnt);
            end
        end
    end

    task automatic idle_for(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(bit u, bit d, bit p, int hold);
        @(negedge clk);
        b_up = u; b_dn = d; b_ps = p;
        repeat (hold) @(negedge clk);
        b_up = 1'b0; b_dn = 1'b0; b_ps = 1'b0;
    endtask

    task automatic expect_val(string req, int exp);
        n_checks++;
        if (count !== 8'(exp)) begin
            n_fail++;
            $display("FAIL %s: count actual %0d expected %0d", req, count, exp);
        end
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        expect_val("R1", 0);
        rst_n = 1'b1;
        // R10: the first step lands LO*HI edges after release; later ones every 2*LO*HI.
        cur_req = "R10";
        push(1, 0, 0, 3);
        idle_for(60);
        // R2: pause in idle leaves the count at zero (checked from reset with a fresh idle).
        cur_req = "R2";
        rst_n = 1'b0; idle_for(2); rst_n = 1'b1;
        push(0, 0, 1, 3);
        idle_for(80);
        expect_val("R2", 0);
        // R3 and R9: down from zero wraps to 255 and keeps decreasing.
        cur_req = "R3";
        push(0, 1, 0, 3);
        idle_for(100);
        // R4: switch to up.
        cur_req = "R4";
        push(1, 0, 0, 3);
        idle_for(100);
        // R5: pause holds the value.
        cur_req = "R5";
        push(0, 0, 1, 3);
        idle_for(120);
        // R6: resume down from the held value.
        cur_req = "R6";
        push(0, 1, 0, 3);
        idle_for(80);
        // R7: a long-held up acts once; a pause during it still pauses.
        cur_req = "R7";
        @(negedge clk); b_up = 1'b1;
        idle_for(60);
        b_ps = 1'b1; idle_for(3); b_ps = 1'b0;
        idle_for(80);
        b_up = 1'b0;
        idle_for(10);
        // R8: all three at once choose up; then down with pause chooses down.
        cur_req = "R8";
        push(1, 1, 1, 3);
        idle_for(60);
        push(0, 1, 1, 3);
        idle_for(60);
        // R9: count up through the 255 to 0 boundary.
        cur_req = "R9";
        push(1, 0, 0, 3);
        idle_for(24 * 260);
        // R1: reset during counting with buttons held.
        cur_req = "R1";
        @(negedge clk); b_dn = 1'b1; rst_n = 1'b0;
        idle_for(2);
        expect_val("R1", 0);
        b_dn = 1'b0; rst_n = 1'b1;
        idle_for(40);
        expect_val("R1", 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL %s: watchdog expired, actual running expected finished", cur_req);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule